// File: doc/BRIEF.md
# Pulse-Handshake Bus Ownership Arbiter

This block is the processor-side logic that lets other bus masters borrow the local bus through shared, active-low request/grant pins. Each pin carries a three-pulse exchange, one clock wide per pulse. The other master pulls the pin low for one clock to ask for the bus. The block pulls the same pin low for one clock to hand the bus over. After that the bus stays floated until the other master pulls the pin low once more to give it back. One dead clock follows the return before a new request is looked at.

The block decides when the ongoing bus cycle may let go of the bus. It watches the bus-cycle state, a locked-instruction flag, a flag for the odd-address low byte of a word and a flag for the first interrupt acknowledge. When the bus is idle the hand-over follows at once. During an active cycle it happens only at the end of a cycle that qualifies. Its outputs are one drive enable per pin (when high, the pad pulls that pin low) and a float-bus signal for the processor's bus drivers.

Top module: `bus_handoff_arb`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every `pinDriveLow` bit and `floatBus` are 0, and a reset during the floated phase ends it.
- R2: A pin sampled low at a rising edge, while the bus is idle (`tState` = 0) and no exchange is in progress, makes that pin's `pinDriveLow` bit high for exactly the next clock.
- R3: `floatBus` rises on the clock after the grant clock and stays high until the granted pin is sampled low again. It is low from the clock after that sample.
- R4: In the clock after the bus is reclaimed, a low level on any pin is ignored. No grant can follow from it.
- R5: When both pins are sampled low at the same edge, pin 0 (bit 0 of `pinIn`) is served.
- R6: While an exchange is in progress, from capture to the end of the dead clock, the other pin is ignored. A release pulse counts only on the granted pin. A low level still present after the dead clock is served as a new request.
- R7: `tState` encoding: 0 idle, 1 first, 2 second, 3 third, 4 wait, 5 last clock of a cycle. A request captured while `tState` is 1 or 2 is granted in the clock after the next edge that sees `tState` = 5, provided all three qualifier flags are low there.
- R8: A request captured while `tState` is 3, 4 or 5 is not served by the current cycle. It is served at the last clock of the following cycle.
- R9: A high `lockActive`, `oddLowByte` or `firstIntAck` at the last clock of a cycle blocks the grant there. The request stays pending and is judged again at the next cycle end.
- R10: A pending request is granted in the clock after an edge that sees the bus idle.
- R11: At most one `pinDriveLow` bit is high at a time, and never while `floatBus` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pinIn | input | NUM_PORTS | Sampled pin levels, low = pulse |
| tState | input | 3 | Current bus-cycle state (encoding in R7) |
| lockActive | input | 1 | A locked instruction is executing |
| oddLowByte | input | 1 | Current cycle is the low byte of an odd-address word |
| firstIntAck | input | 1 | Current cycle is the first interrupt acknowledge |
| pinDriveLow | output | NUM_PORTS | Pull the matching pin low this clock |
| floatBus | output | 1 | Bus and control lines released to the other master |

## Verification
Two functions can fall in the same clock. One is the arbitration between the two pins. The other is the end of an exchange, where the release sample, the dead clock and a waiting request on the other pin meet. The bench pulls both pins low at one edge to judge priority. It then holds the losing pin low through the grant, the floated phase, the release and the dead clock. A grant on the second pin must appear only in the clock after the first edge that follows the dead clock. Separately, a request is placed at each bus-cycle state, and the qualifier flags are raised one at a time at cycle ends, so that the grant clock can be checked against the cycle position.

// File: rtl/bus_handoff_pkg.sv
package bus_handoff_pkg;

  typedef enum logic [2:0] {
    T_IDLE  = 3'd0,
    T_ONE   = 3'd1,
    T_TWO   = 3'd2,
    T_THREE = 3'd3,
    T_WAIT  = 3'd4,
    T_FOUR  = 3'd5
  } tstate_e;

  typedef enum logic [2:0] {
    ST_WATCH,
    ST_PEND,
    ST_GRANT,
    ST_HOLD,
    ST_DEAD
  } arb_state_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;     // latch winning pin and its cycle position
    logic armEarly;    // a cycle ended with the request still waiting
    logic startGrant;  // drive the grant pulse next clock
    logic enterHold;   // float the bus next clock
    logic leaveHold;   // reclaim the bus next clock
  } dp_ctrl_t;

endpackage

// File: rtl/bus_handoff_dp.sv
module bus_handoff_dp
  import bus_handoff_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pinIn,
  input  logic [2:0]           tState,
  input  logic                 lockActive,
  input  logic                 oddLowByte,
  input  logic                 firstIntAck,
  input  dp_ctrl_t             ctrl,
  output logic                 reqSeen,
  output logic                 busIdle,
  output logic                 cycleEnd,
  output logic                 eligible,
  output logic                 releaseSeen,
  output logic [NUM_PORTS-1:0] pinDriveLow,
  output logic                 floatBus
);

  logic [NUM_PORTS-1:0] reqLow;
  logic [PORT_W-1:0]    winIdx;
  logic [PORT_W-1:0]    ownerIdx;
  logic [PORT_W-1:0]    tgtIdx;
  logic                 earlyQ;
  logic                 earlyNow;
  logic                 floatQ;
  logic                 qualOk;

  assign reqLow = ~pinIn;

  // lowest index wins
  always_comb begin
    winIdx  = '0;
    reqSeen = |reqLow;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (reqLow[i]) winIdx = PORT_W'(i);
    end
  end

  assign busIdle  = (tState == T_IDLE);
  assign cycleEnd = (tState == T_FOUR);
  assign earlyNow = (tState == T_IDLE) || (tState == T_ONE) || (tState == T_TWO);
  assign qualOk   = !lockActive && !oddLowByte && !firstIntAck;
  assign eligible = busIdle || (cycleEnd && earlyQ && qualOk);

  always_ff @(posedge clk) begin
    if (rst) begin
      ownerIdx <= '0;
      earlyQ   <= 1'b0;
    end else begin
      if (ctrl.capture) begin
        ownerIdx <= winIdx;
        earlyQ   <= earlyNow;
      end else if (ctrl.armEarly) begin
        earlyQ   <= 1'b1;
      end
    end
  end

  assign releaseSeen = reqLow[ownerIdx];
  assign tgtIdx      = ctrl.capture ? winIdx : ownerIdx;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_drive
    logic driveQ;
    always_ff @(posedge clk) begin
      if (rst) driveQ <= 1'b0;
      else     driveQ <= ctrl.startGrant && (tgtIdx == PORT_W'(g));
    end
    assign pinDriveLow[g] = driveQ;
  end

  always_ff @(posedge clk) begin
    if (rst)                 floatQ <= 1'b0;
    else if (ctrl.enterHold) floatQ <= 1'b1;
    else if (ctrl.leaveHold) floatQ <= 1'b0;
  end

  assign floatBus = floatQ;

endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
  import bus_handoff_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reqSeen,
  input  logic     busIdle,
  input  logic     cycleEnd,
  input  logic     eligible,
  input  logic     releaseSeen,
  output dp_ctrl_t ctrl
);

  arb_state_e stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    ctrl      = '0;
    unique case (stateQ)
      ST_WATCH: begin
        if (reqSeen) begin
          ctrl.capture = 1'b1;
          if (busIdle) begin
            ctrl.startGrant = 1'b1;
            stateNext       = ST_GRANT;
          end else begin
            stateNext = ST_PEND;
          end
        end
      end
      ST_PEND: begin
        if (eligible) begin
          ctrl.startGrant = 1'b1;
          stateNext       = ST_GRANT;
        end else if (cycleEnd) begin
          ctrl.armEarly = 1'b1;
        end
      end
      ST_GRANT: begin
        ctrl.enterHold = 1'b1;
        stateNext      = ST_HOLD;
      end
      ST_HOLD: begin
        if (releaseSeen) begin
          ctrl.leaveHold = 1'b1;
          stateNext      = ST_DEAD;
        end
      end
      ST_DEAD: stateNext = ST_WATCH;
      default: stateNext = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_WATCH;
    else     stateQ <= stateNext;
  end

endmodule

// File: rtl/bus_handoff_arb.sv
module bus_handoff_arb
  import bus_handoff_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pinIn,
  input  logic [2:0]           tState,
  input  logic                 lockActive,
  input  logic                 oddLowByte,
  input  logic                 firstIntAck,
  output logic [NUM_PORTS-1:0] pinDriveLow,
  output logic                 floatBus
);

  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  dp_ctrl_t ctrl;
  logic     reqSeen, busIdle, cycleEnd, eligible, releaseSeen;

  bus_handoff_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .reqSeen     (reqSeen),
    .busIdle     (busIdle),
    .cycleEnd    (cycleEnd),
    .eligible    (eligible),
    .releaseSeen (releaseSeen),
    .ctrl        (ctrl)
  );

  bus_handoff_dp #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .pinIn       (pinIn),
    .tState      (tState),
    .lockActive  (lockActive),
    .oddLowByte  (oddLowByte),
    .firstIntAck (firstIntAck),
    .ctrl        (ctrl),
    .reqSeen     (reqSeen),
    .busIdle     (busIdle),
    .cycleEnd    (cycleEnd),
    .eligible    (eligible),
    .releaseSeen (releaseSeen),
    .pinDriveLow (pinDriveLow),
    .floatBus    (floatBus)
  );

endmodule

// File: rtl/bus_handoff_chk.sv
module bus_handoff_chk #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           tState,
  input logic                 lockActive,
  input logic                 oddLowByte,
  input logic                 firstIntAck,
  input logic [NUM_PORTS-1:0] pinDriveLow,
  input logic                 floatBus
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pinDriveLow == '0 && !floatBus));

  assert_grant_single_clock_R2: assert property (@(posedge clk) disable iff (rst)
    (|pinDriveLow) |=> !(|pinDriveLow));

  assert_float_follows_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (|pinDriveLow) |=> floatBus);

  assert_float_rises_after_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(floatBus) |-> $past(|pinDriveLow));

  assert_dead_clock_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(floatBus) |=> !(|pinDriveLow));

  assert_grant_position_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(|pinDriveLow) |-> ($past(tState) == 3'd5 || $past(tState) == 3'd0));

  assert_qualifiers_block_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(|pinDriveLow) && $past(tState) == 3'd5)
      |-> (!$past(lockActive) && !$past(oddLowByte) && !$past(firstIntAck)));

  assert_single_drive_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pinDriveLow));

  assert_no_drive_while_float_R11: assert property (@(posedge clk) disable iff (rst)
    !((|pinDriveLow) && floatBus));

endmodule

bind bus_handoff_arb bus_handoff_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tState      (tState),
  .lockActive  (lockActive),
  .oddLowByte  (oddLowByte),
  .firstIntAck (firstIntAck),
  .pinDriveLow (pinDriveLow),
  .floatBus    (floatBus)
);

// File: tb/bus_handoff_arb_bench.sv
`timescale 1ns/1ps
module bus_handoff_arb_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] pinIn;
  logic [2:0] tState;
  logic       lockActive, oddLowByte, firstIntAck;
  logic [1:0] pinDriveLow;
  logic       floatBus;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bus_handoff_arb #(.NUM_PORTS(2)) u_bus_handoff_arb (
    .clk         (clk),
    .rst         (rst),
    .pinIn       (pinIn),
    .tState      (tState),
    .lockActive  (lockActive),
    .oddLowByte  (oddLowByte),
    .firstIntAck (firstIntAck),
    .pinDriveLow (pinDriveLow),
    .floatBus    (floatBus)
  );

  // row: {pins, tState, lock/odd/ack, expected drive, expected float, requirement}
  localparam int ROWS = 55;
  localparam logic [15:0] VEC [ROWS] = '{
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd1},   // 0  quiet, R1
    {2'b10, 3'd0, 3'b000, 2'b01, 1'b0, 5'd2},   // 1  idle request pin0, R2
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b1, 5'd3},   // 2  floated, R3
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b1, 5'd3},   // 3
    {2'b10, 3'd0, 3'b000, 2'b00, 1'b0, 5'd3},   // 4  release
    {2'b10, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 5  dead clock ignores, R4
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 6
    {2'b00, 3'd0, 3'b000, 2'b01, 1'b0, 5'd5},   // 7  both low, R5
    {2'b01, 3'd0, 3'b000, 2'b00, 1'b1, 5'd6},   // 8  pin1 ignored, R6
    {2'b01, 3'd0, 3'b000, 2'b00, 1'b1, 5'd6},   // 9  not a release, R6
    {2'b10, 3'd0, 3'b000, 2'b00, 1'b0, 5'd3},   // 10 release pin0
    {2'b01, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 11 dead clock, R4
    {2'b01, 3'd0, 3'b000, 2'b10, 1'b0, 5'd6},   // 12 pin1 served after dead, R6
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b1, 5'd3},   // 13
    {2'b01, 3'd0, 3'b000, 2'b00, 1'b0, 5'd3},   // 14 release pin1
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 15
    {2'b10, 3'd1, 3'b000, 2'b00, 1'b0, 5'd7},   // 16 request in first clock, R7
    {2'b11, 3'd2, 3'b000, 2'b00, 1'b0, 5'd7},   // 17
    {2'b11, 3'd3, 3'b000, 2'b00, 1'b0, 5'd7},   // 18
    {2'b11, 3'd5, 3'b000, 2'b01, 1'b0, 5'd7},   // 19 grant after cycle end
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b1, 5'd3},   // 20
    {2'b10, 3'd1, 3'b000, 2'b00, 1'b0, 5'd3},   // 21
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 22
    {2'b10, 3'd3, 3'b000, 2'b00, 1'b0, 5'd8},   // 23 late request, R8
    {2'b11, 3'd5, 3'b000, 2'b00, 1'b0, 5'd8},   // 24 this cycle end not used
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b0, 5'd8},   // 25
    {2'b11, 3'd2, 3'b000, 2'b00, 1'b0, 5'd8},   // 26
    {2'b11, 3'd5, 3'b000, 2'b01, 1'b0, 5'd8},   // 27 next cycle end grants
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b1, 5'd3},   // 28
    {2'b10, 3'd1, 3'b000, 2'b00, 1'b0, 5'd3},   // 29
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 30
    {2'b10, 3'd2, 3'b000, 2'b00, 1'b0, 5'd7},   // 31 request in second clock, R7
    {2'b11, 3'd5, 3'b100, 2'b00, 1'b0, 5'd9},   // 32 locked, R9
    {2'b11, 3'd1, 3'b100, 2'b00, 1'b0, 5'd9},   // 33
    {2'b11, 3'd5, 3'b010, 2'b00, 1'b0, 5'd9},   // 34 odd low byte, R9
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b0, 5'd9},   // 35
    {2'b11, 3'd5, 3'b001, 2'b00, 1'b0, 5'd9},   // 36 first acknowledge, R9
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b0, 5'd9},   // 37
    {2'b11, 3'd5, 3'b000, 2'b01, 1'b0, 5'd9},   // 38 all clear, R9
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b1, 5'd3},   // 39
    {2'b10, 3'd1, 3'b000, 2'b00, 1'b0, 5'd3},   // 40
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 41
    {2'b01, 3'd3, 3'b000, 2'b00, 1'b0, 5'd8},   // 42 pin1 late request, R8
    {2'b11, 3'd5, 3'b000, 2'b00, 1'b0, 5'd8},   // 43
    {2'b11, 3'd0, 3'b000, 2'b10, 1'b0, 5'd10},  // 44 bus went idle, R10
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b1, 5'd3},   // 45
    {2'b01, 3'd0, 3'b000, 2'b00, 1'b0, 5'd3},   // 46
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4},   // 47
    {2'b10, 3'd4, 3'b000, 2'b00, 1'b0, 5'd8},   // 48 request in wait clock, R8
    {2'b11, 3'd5, 3'b000, 2'b00, 1'b0, 5'd8},   // 49
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b0, 5'd8},   // 50
    {2'b11, 3'd5, 3'b000, 2'b01, 1'b0, 5'd8},   // 51
    {2'b11, 3'd1, 3'b000, 2'b00, 1'b1, 5'd11},  // 52 float without drive, R11
    {2'b10, 3'd1, 3'b000, 2'b00, 1'b0, 5'd3},   // 53
    {2'b11, 3'd0, 3'b000, 2'b00, 1'b0, 5'd4}    // 54
  };

  task automatic apply(input logic [1:0] p, input logic [2:0] t, input logic [2:0] f);
    pinIn       = p;
    tState      = t;
    lockActive  = f[2];
    oddLowByte  = f[1];
    firstIntAck = f[0];
  endtask

  task automatic expect_out(input logic [1:0] d, input logic fl, input int req, input int tagRow);
    checks++;
    if (pinDriveLow !== d || floatBus !== fl) begin
      errors++;
      $display("FAIL R%0d step %0d: drive=%b float=%b expected drive=%b float=%b",
               req, tagRow, pinDriveLow, floatBus, d, fl);
    end
  endtask

  initial begin
    rst = 1'b1;
    apply(2'b11, 3'd0, 3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out(2'b00, 1'b0, 1, -1);             // R1 during reset
    rst = 1'b0;

    for (int r = 0; r < ROWS; r++) begin
      apply(VEC[r][15:14], VEC[r][13:11], VEC[r][10:8]);
      @(posedge clk);
      @(negedge clk);
      expect_out(VEC[r][7:6], VEC[r][5], int'(VEC[r][4:0]), r);
    end

    // R1: reset in the middle of the floated phase
    apply(2'b10, 3'd0, 3'b000);
    @(posedge clk); @(negedge clk);
    expect_out(2'b01, 1'b0, 2, 100);
    apply(2'b11, 3'd0, 3'b000);
    @(posedge clk); @(negedge clk);
    expect_out(2'b00, 1'b1, 3, 101);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_out(2'b00, 1'b0, 1, 102);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    expect_out(2'b00, 1'b0, 1, 103);
    // fresh request on pin1 after the reset
    apply(2'b01, 3'd0, 3'b000);
    @(posedge clk); @(negedge clk);
    expect_out(2'b10, 1'b0, 2, 104);
    apply(2'b11, 3'd0, 3'b000);
    @(posedge clk); @(negedge clk);
    expect_out(2'b00, 1'b1, 3, 105);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule